// File: doc/BRIEF.md
# Polyphase Scaler Coefficient Store

This block holds the coefficient table of a polyphase scaling filter with 7 taps and 17 phases, which makes 119 coefficients of 16 bits each. A host loads the table through two registers that share one write strobe. The first is an index register that selects a 32-bit word and holds an auto-increment flag. The second is a data register that takes one packed word at a time. Each word carries two coefficients in flat order, so a phase's taps can start in one word and end in the next.

The filter reads the table through a separate port. It presents a phase number and gets all seven taps of that phase in the same cycle, with no register on the path.

A one-pulse command fills the whole table with a nearest-neighbour pattern, one word per clock. A busy flag stays high while the fill runs, and the host cannot write during that time.

Top module: `scaler_coef_ram`

## Requirements
- R1: Flat coefficient k belongs to phase k/7 and tap k%7. With `rd_phase` = p, tap t of phase p appears on `rd_coefs[16t+15:16t]` combinationally.
- R2: Word n stores coefficient 2n from data bits [15:0] and coefficient 2n+1 from data bits [31:16]. The valid words are 0 to 59.
- R3: In word 59, bits [15:0] give tap 6 of phase 16. Bits [31:16] of that word are discarded.
- R4: A write with `host_sel`=0 loads the index from data bits [5:0] and the auto-increment flag from data bit 16. Writing the value 0 selects word 0 and clears the flag.
- R5: When the flag is set, each accepted data write (`host_sel`=1) moves the index on by one.
- R6: When the flag is clear, data writes go to the current index and leave the index unchanged.
- R7: A data write is dropped while the index is 60 or above, and the index does not move. Auto-increment therefore stops at 60 after word 59 is written.
- R8: A pulse on `nn_load` raises `busy` from the next cycle for exactly 60 cycles. During that time the table is filled with 0x0800 on tap 3 of every phase and 0x3000 on every other tap.
- R9: Host writes to either register are ignored while `busy` is high and in the cycle `nn_load` is asserted. A new `nn_load` pulse during a fill does not restart or extend the fill.
- R10: After reset, every coefficient reads 0x3000, the index is 0, auto-increment is off and `busy` is low.
- R11: When `rd_phase` is above 16, all seven taps read 0x3000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Register write strobe |
| host_sel | input | 1 | 0 selects the index register, 1 selects the data register |
| host_wdata | input | 32 | Write data |
| nn_load | input | 1 | Starts the nearest-neighbour fill |
| busy | output | 1 | Fill in progress |
| rd_phase | input | 5 | Phase requested by the filter |
| rd_coefs | output | 112 | Seven taps of the requested phase, tap 0 in the low bits |

## Verification
Several states are hard to reach from the ports. One is the end of an auto-increment stream, where the index has moved past the last word and further data must be dropped. The bench gets there by streaming all 60 words and then writing one more word, which must change nothing. The other is a host access that collides with a running fill. Here the bench writes the index with auto-increment set, writes a data word and pulses `nn_load` again, all partway through the fill. It then checks that the fill length is still 60 cycles and that the index chosen before the fill still steers the next data write.

// File: rtl/scaler_coef_pkg.sv
package scaler_coef_pkg;

    // coefficient encodings used by the filter
    localparam logic [15:0] COEF_ZERO  = 16'h3000;
    localparam logic [15:0] COEF_UNITY = 16'h0800;

    function automatic int words_needed(input int ncoef, input int per_word);
        return (ncoef + per_word - 1) / per_word;
    endfunction

endpackage

// File: rtl/coef_idx_ctrl.sv
module coef_idx_ctrl #(
    parameter int NWORDS = 60,
    parameter int IW     = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          idx_wr,
    input  logic [IW-1:0] idx_val,
    input  logic          idx_auto,
    input  logic          dat_wr,
    input  logic          blocked,
    output logic          wen,
    output logic [IW-1:0] widx
);

    typedef struct packed {
        logic [IW-1:0] idx;
        logic          autoinc;
    } ictl_t;

    ictl_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        wen  = 1'b0;
        if (!blocked) begin
            if (idx_wr) begin
                st_d.idx     = idx_val;
                st_d.autoinc = idx_auto;
            end else if (dat_wr && (int'(st_q.idx) < NWORDS)) begin
                wen = 1'b1;
                if (st_q.autoinc) begin
                    st_d.idx = st_q.idx + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign widx = st_q.idx;

    p_auto_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wen && st_q.autoinc) |=> (st_q.idx == $past(st_q.idx) + 1'b1));

    p_hold_idx_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_wr && !idx_wr && !st_q.autoinc) |=> $stable(st_q.idx));

    p_range_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_wr && !idx_wr && (int'(st_q.idx) >= NWORDS)) |=> $stable(st_q));

    p_blocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (blocked && (idx_wr || dat_wr)) |=> $stable(st_q));

endmodule

// File: rtl/coef_nn_seq.sv
module coef_nn_seq
    import scaler_coef_pkg::*;
#(
    parameter int TAPS   = 7,
    parameter int CW     = 16,
    parameter int NWORDS = 60,
    parameter int IW     = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    output logic            busy,
    output logic            fill_wr,
    output logic [IW-1:0]   fill_addr,
    output logic [2*CW-1:0] fill_data
);

    localparam int CENTER = TAPS / 2;

    typedef struct packed {
        logic          busy;
        logic [IW-1:0] cnt;
    } seq_t;

    seq_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!st_q.busy) begin
            if (start) begin
                st_d.busy = 1'b1;
                st_d.cnt  = '0;
            end
        end else if (int'(st_q.cnt) == NWORDS - 1) begin
            st_d.busy = 1'b0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar h = 0; h < 2; h++) begin : g_half
        always_comb begin
            if (((2 * int'(st_q.cnt) + h) % TAPS) == CENTER) begin
                fill_data[h*CW +: CW] = COEF_UNITY[CW-1:0];
            end else begin
                fill_data[h*CW +: CW] = COEF_ZERO[CW-1:0];
            end
        end
    end

    assign busy      = st_q.busy;
    assign fill_wr   = st_q.busy;
    assign fill_addr = st_q.cnt;

    p_fill_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.busy) |-> (int'($past(st_q.cnt)) == NWORDS - 1));

    p_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !st_q.busy) |=> (st_q.busy && st_q.cnt == '0));

    p_no_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && int'(st_q.cnt) != NWORDS - 1) |=> (st_q.cnt == $past(st_q.cnt) + 1'b1));

endmodule

// File: rtl/coef_store.sv
module coef_store
    import scaler_coef_pkg::*;
#(
    parameter int NCOEF = 119,
    parameter int CW    = 16,
    parameter int IW    = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [IW-1:0]       waddr,
    input  logic [2*CW-1:0]     wdata,
    output logic [NCOEF*CW-1:0] coefs
);

    logic [CW-1:0] mem_d [NCOEF];
    logic [CW-1:0] mem_q [NCOEF];

    // coefficient k sits in word k/2, low half when k is even
    always_comb begin
        mem_d = mem_q;
        if (we) begin
            for (int k = 0; k < NCOEF; k++) begin
                if (int'(waddr) == k / 2) begin
                    mem_d[k] = (k % 2 == 1) ? wdata[2*CW-1:CW] : wdata[CW-1:0];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < NCOEF; k++) begin
                mem_q[k] <= COEF_ZERO[CW-1:0];
            end
        end else begin
            mem_q <= mem_d;
        end
    end

    for (genvar g = 0; g < NCOEF; g++) begin : g_flat
        assign coefs[g*CW +: CW] = mem_q[g];
    end

endmodule

// File: rtl/coef_phase_sel.sv
module coef_phase_sel
    import scaler_coef_pkg::*;
#(
    parameter int PHASES = 17,
    parameter int TAPS   = 7,
    parameter int CW     = 16,
    parameter int PW     = 5
) (
    input  logic [PHASES*TAPS*CW-1:0] coefs,
    input  logic [PW-1:0]             phase,
    output logic [TAPS*CW-1:0]        taps
);

    for (genvar t = 0; t < TAPS; t++) begin : g_tap
        logic [CW-1:0] sel;
        always_comb begin
            sel = COEF_ZERO[CW-1:0];
            for (int p = 0; p < PHASES; p++) begin
                if (int'(phase) == p) begin
                    sel = coefs[(p*TAPS + t)*CW +: CW];
                end
            end
        end
        assign taps[t*CW +: CW] = sel;
    end

endmodule

// File: rtl/scaler_coef_ram.sv
module scaler_coef_ram
    import scaler_coef_pkg::*;
#(
    parameter int PHASES   = 17,
    parameter int TAPS     = 7,
    parameter int CW       = 16,
    parameter int AUTO_BIT = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          host_wr,
    input  logic                          host_sel,
    input  logic [2*CW-1:0]               host_wdata,
    input  logic                          nn_load,
    output logic                          busy,
    input  logic [$clog2(PHASES)-1:0]     rd_phase,
    output logic [TAPS*CW-1:0]            rd_coefs
);

    localparam int NCOEF  = PHASES * TAPS;
    localparam int NWORDS = words_needed(NCOEF, 2);
    localparam int IW     = $clog2(NWORDS + 1);
    localparam int PW     = $clog2(PHASES);
    localparam int DW     = 2 * CW;

    logic            idx_wr, dat_wr, blocked;
    logic            host_wen;
    logic [IW-1:0]   widx;
    logic            fill_wr;
    logic [IW-1:0]   fill_addr;
    logic [DW-1:0]   fill_data;
    logic            st_we;
    logic [IW-1:0]   st_addr;
    logic [DW-1:0]   st_data;
    logic [NCOEF*CW-1:0] coefs;

    assign idx_wr  = host_wr && !host_sel;
    assign dat_wr  = host_wr && host_sel;
    assign blocked = busy || nn_load;

    coef_idx_ctrl #(.NWORDS(NWORDS), .IW(IW)) i_idx (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx_wr   (idx_wr),
        .idx_val  (host_wdata[IW-1:0]),
        .idx_auto (host_wdata[AUTO_BIT]),
        .dat_wr   (dat_wr),
        .blocked  (blocked),
        .wen      (host_wen),
        .widx     (widx)
    );

    coef_nn_seq #(.TAPS(TAPS), .CW(CW), .NWORDS(NWORDS), .IW(IW)) i_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (nn_load),
        .busy      (busy),
        .fill_wr   (fill_wr),
        .fill_addr (fill_addr),
        .fill_data (fill_data)
    );

    assign st_we   = fill_wr || host_wen;
    assign st_addr = fill_wr ? fill_addr : widx;
    assign st_data = fill_wr ? fill_data : host_wdata;

    coef_store #(.NCOEF(NCOEF), .CW(CW), .IW(IW)) i_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (st_we),
        .waddr (st_addr),
        .wdata (st_data),
        .coefs (coefs)
    );

    coef_phase_sel #(.PHASES(PHASES), .TAPS(TAPS), .CW(CW), .PW(PW)) i_sel (
        .coefs (coefs),
        .phase (rd_phase),
        .taps  (rd_coefs)
    );

    p_one_writer_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(fill_wr && host_wen));

endmodule

// File: tb/test_scaler_coef_ram.sv
module test_scaler_coef_ram;

    localparam int PH = 17;
    localparam int TP = 7;
    localparam int NC = PH * TP;
    localparam int NW = 60;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         host_wr = 1'b0;
    logic         host_sel = 1'b0;
    logic [31:0]  host_wdata = '0;
    logic         nn_load = 1'b0;
    logic         busy;
    logic [4:0]   rd_phase = '0;
    logic [111:0] rd_coefs;

    int n_run = 0;
    int n_fail = 0;
    int busy_cycles = 0;
    bit finished = 0;

    logic [15:0] exp_c [NC];
    int          m_idx;
    bit          m_auto;

    always #10 clk = ~clk;

    scaler_coef_ram i_scaler_coef_ram (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_wr    (host_wr),
        .host_sel   (host_sel),
        .host_wdata (host_wdata),
        .nn_load    (nn_load),
        .busy       (busy),
        .rd_phase   (rd_phase),
        .rd_coefs   (rd_coefs)
    );

    always @(negedge clk) if (busy) busy_cycles++;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    // one register write; the model is updated only when the write should land
    task automatic host(input logic sel, input logic [31:0] d, input bit model);
        @(negedge clk);
        host_wr = 1'b1; host_sel = sel; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
        if (model) begin
            if (!sel) begin
                m_idx = int'(d[5:0]); m_auto = d[16];
            end else if (m_idx < NW) begin
                exp_c[2*m_idx] = d[15:0];
                if (2*m_idx + 1 < NC) exp_c[2*m_idx+1] = d[31:16];
                if (m_auto) m_idx++;
            end
        end
    endtask

    task automatic check_phases(input string req);
        for (int p = 0; p < PH; p++) begin
            rd_phase = p[4:0];
            #1;
            for (int t = 0; t < TP; t++) begin
                chk(rd_coefs[t*16 +: 16] == exp_c[p*TP+t], req,
                    $sformatf("phase %0d tap %0d", p, t),
                    {16'h0, rd_coefs[t*16 +: 16]}, {16'h0, exp_c[p*TP+t]});
            end
        end
        rd_phase = '0;
    endtask

    task automatic tap_of(input int p, input int t, output logic [15:0] v);
        rd_phase = p[4:0];
        #1;
        v = rd_coefs[t*16 +: 16];
        rd_phase = '0;
    endtask

    task automatic t_reset;
        chk(busy == 1'b0, "R10", "busy after reset", {31'h0, busy}, 32'h0);
        check_phases("R10");
        // index 0, no auto: both writes land in word 0
        host(1'b1, 32'h0A0B_0C0D, 1'b1);
        host(1'b1, 32'h1A1B_1C1D, 1'b1);
        check_phases("R10");
    endtask

    task automatic t_stream;
        logic [15:0] v;
        host(1'b0, 32'h0001_0000, 1'b1);
        for (int n = 0; n < NW; n++) begin
            logic [15:0] hi;
            hi = (n == NW - 1) ? 16'hDEAD : 16'h2000 + 16'(2*n + 1);
            host(1'b1, {hi, 16'h2000 + 16'(2*n)}, 1'b1);
        end
        check_phases("R2");
        tap_of(1, 0, v);
        chk(v == 16'h2007, "R1", "phase 1 tap 0", {16'h0, v}, 32'h2007);
        tap_of(0, 6, v);
        chk(v == 16'h2006, "R5", "phase 0 tap 6", {16'h0, v}, 32'h2006);
        tap_of(16, 6, v);
        chk(v == 16'h2076, "R3", "phase 16 tap 6", {16'h0, v}, 32'h2076);
        // index is now past the end: this write must not land
        host(1'b1, 32'hBEEF_BEEF, 1'b1);
        check_phases("R7");
    endtask

    task automatic t_noauto;
        logic [15:0] v;
        host(1'b0, 32'h0000_0003, 1'b1);
        host(1'b1, 32'h1111_2222, 1'b1);
        host(1'b1, 32'h3333_4444, 1'b1);
        tap_of(0, 6, v);
        chk(v == 16'h4444, "R6", "phase 0 tap 6", {16'h0, v}, 32'h4444);
        tap_of(1, 0, v);
        chk(v == 16'h3333, "R6", "phase 1 tap 0", {16'h0, v}, 32'h3333);
        check_phases("R6");
    endtask

    task automatic t_clear;
        logic [15:0] v;
        host(1'b0, 32'h0001_000A, 1'b1);
        host(1'b1, 32'hAAAA_AAA0, 1'b1);
        host(1'b0, 32'h0000_000A, 1'b1);
        host(1'b1, 32'hBBBB_BBB0, 1'b1);
        host(1'b1, 32'hCCCC_CCC0, 1'b1);
        tap_of(2, 6, v);
        chk(v == 16'hCCC0, "R4", "phase 2 tap 6", {16'h0, v}, 32'hCCC0);
        check_phases("R4");
    endtask

    task automatic t_range;
        host(1'b0, 32'h0001_003F, 1'b1);
        host(1'b1, 32'h7777_7777, 1'b1);
        host(1'b0, 32'h0000_003C, 1'b1);
        host(1'b1, 32'h6666_6666, 1'b1);
        check_phases("R7");
    endtask

    task automatic t_nn;
        host(1'b0, 32'h0000_0005, 1'b1);
        busy_cycles = 0;
        @(negedge clk); nn_load = 1'b1;
        @(negedge clk); nn_load = 1'b0;
        repeat (5) @(negedge clk);
        host(1'b0, 32'h0001_0000, 1'b0);
        host(1'b1, 32'hFFFF_FFFF, 1'b0);
        @(negedge clk); nn_load = 1'b1;
        @(negedge clk); nn_load = 1'b0;
        while (busy) @(negedge clk);
        @(negedge clk);
        chk(busy_cycles == NW, "R8", "busy length", busy_cycles, NW);
        for (int k = 0; k < NC; k++) exp_c[k] = (k % TP == 3) ? 16'h0800 : 16'h3000;
        check_phases("R8");
        // index 5 without auto must have survived the blocked writes
        host(1'b1, 32'h5555_6666, 1'b1);
        host(1'b1, 32'h5555_6667, 1'b1);
        check_phases("R9");
    endtask

    task automatic t_phase_oob;
        for (int p = 17; p < 32; p += 7) begin
            rd_phase = p[4:0];
            #1;
            for (int t = 0; t < TP; t++) begin
                chk(rd_coefs[t*16 +: 16] == 16'h3000, "R11",
                    $sformatf("phase %0d tap %0d", p, t),
                    {16'h0, rd_coefs[t*16 +: 16]}, 32'h3000);
            end
        end
        rd_phase = '0;
    endtask

    initial begin
        for (int k = 0; k < NC; k++) exp_c[k] = 16'h3000;
        m_idx = 0;
        m_auto = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_stream;
        t_noauto;
        t_clear;
        t_range;
        t_nn;
        t_phase_oob;
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog run did not end actual=timeout expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule